// File: doc/BRIEF.md
# Level-1 Readout Latency Buffer

Every bunch crossing, this block stores the record for that crossing in a circular latency store. The record holds tower energies, hit multiplicities and region-of-interest coordinates. With each record it also stores the current 12-bit crossing number. The store is 128 crossings deep, which covers a 3.2 µs trigger latency at 40 MHz.

When a level-1 accept strobe arrives, the block reads back the record written `lat_offset` crossings earlier. It places that record, together with its crossing number, in a derandomising queue. This lets accepts that arrive close together wait for the output.

A framer takes records from the queue and sends each one as a frame of words. Each frame has a header carrying the crossing number, then the data words, then a trailer that carries an error flag. The readout-enable input gates the output stream.

Top module: `l1a_readout_buffer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_valid` and `busy` are 0.
- R2: The crossing counter starts at 0 after reset and advances by one every cycle. After 4095 it wraps to 0.
- R3: A cycle with `orbit` high makes the crossing number of the following cycle 0.
- R4: An accept in cycle n, with `lat_offset` = L (1..127), returns the record presented in cycle n−L and the crossing number of that cycle.
- R5: Each output word is `out_word[17:16]` = type and `out_word[15:0]` = payload. The type codes are 1 = header, 2 = data and 3 = trailer. A frame is one header (crossing number in bits [11:0], upper bits 0), then data word 0 = tower value, then data word 1 = {hits, roi}, then one trailer.
- R6: While `readout_en` is low, `out_valid` is 0 and the frame in progress holds its position. It resumes from the same word when `readout_en` rises.
- R7: Accepted records leave in the order they were accepted. Up to eight records wait in the queue, plus one in the framer, and none is lost.
- R8: `busy` is high exactly when the queue holds six or more records.
- R9: An accept that arrives while the queue is full is discarded. Bit 0 of the next trailer sent is then 1. Every trailer with no discard since the previous trailer has bit 0 = 0.
- R10: When records are waiting and `readout_en` stays high, frames follow one another with no idle word between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tower_in | input | 16 | Tower data for the current crossing |
| hits_in | input | 8 | Hit multiplicities for the current crossing |
| roi_in | input | 8 | Region-of-interest coordinates for the current crossing |
| orbit | input | 1 | Orbit marker; clears the crossing number |
| l1_accept | input | 1 | Level-1 accept strobe |
| lat_offset | input | 7 | Number of crossings between the accepted crossing and the accept |
| readout_en | input | 1 | Lets the framer send words |
| out_valid | output | 1 | A frame word is present this cycle |
| out_word | output | 18 | Frame word: type in [17:16], payload in [15:0] |
| busy | output | 1 | Queue is almost full |

## Verification
A wrong read pointer or a wrong offset subtraction shows up in the first accepted frame. The data words then carry another crossing's record, and the header shows a crossing number that is off by the same amount.

A wrong crossing counter shows up in the header of the first frame taken across an orbit or a 4095 wrap. Queue pointer or count errors show up as frames out of order, a missing frame, a duplicated frame, or `busy` asserting one cycle away from the sixth record. Those errors appear within a few frames of a burst of accepts.

A lost discard flag or a stuck discard flag shows up in the very next trailer.

// File: rtl/rob_pkg.sv
// Shared definitions for the level-1 readout latency buffer.
package rob_pkg;
    localparam int BCN_W = 12;

    // Framer state doubles as the output word type code.
    typedef enum logic [1:0] {
        WT_IDLE = 2'd0,
        WT_HDR  = 2'd1,
        WT_DATA = 2'd2,
        WT_TRL  = 2'd3
    } word_type_t;
endpackage

// File: rtl/rob_xing_counter.sv
// Bunch-crossing number counter.
// Counts one step per clock and wraps at 2^W. An orbit marker makes the next value zero.
// Assumes one clock per crossing.
module rob_xing_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         orbit,
    output logic [W-1:0] bcn
);
    localparam logic [W-1:0] MAXV = '1;

    // Advance the crossing number, or clear it on orbit.
    always_ff @(posedge clk) begin
        if (!rst_n)     bcn <= '0;
        else if (orbit) bcn <= '0;
        else            bcn <= bcn + 1'b1;
    end

    // R3
    orbit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        orbit |=> (bcn == '0));
    // R2
    bcn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!orbit && bcn != MAXV) |=> (bcn == $past(bcn) + 1'b1));
    // R2
    bcn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!orbit && bcn == MAXV) |=> (bcn == '0));
endmodule

// File: rtl/rob_latency_ring.sv
// Circular latency store.
// Writes one entry every clock. Reads combinationally the entry written OFFSET clocks earlier.
// Assumes 1 <= OFFSET <= DEPTH-1 and that at least OFFSET clocks have passed since reset.
module rob_latency_ring #(
    parameter int W     = 44,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] offset,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;

    // Move the write pointer one slot per crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_ptr <= '0;
        else        wr_ptr <= wr_ptr + 1'b1;
    end

    // Store the current crossing's entry.
    always_ff @(posedge clk) begin
        mem[wr_ptr] <= wr_data;
    end

    // Read back the entry that trails the write pointer.
    always_comb rd_data = mem[wr_ptr - offset];

    // R4
    offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offset != '0);
endmodule

// File: rtl/rob_accept_fifo.sv
// Derandomising queue for accepted records.
// A push that arrives while the queue is full is discarded and reported on `dropped`.
// Assumes pop is raised only while not_empty is high.
module rob_accept_fifo #(
    parameter int W          = 44,
    parameter int DEPTH      = 8,
    parameter int BUSY_LEVEL = 6,
    localparam int PW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_req,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         almost_full,
    output logic         dropped
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          full, push, take;

    always_comb begin
        full        = (cnt_q == CW'(DEPTH));
        push        = push_req && !full;
        dropped     = push_req && full;
        not_empty   = (cnt_q != '0);
        take        = pop && not_empty;
        almost_full = (cnt_q >= CW'(BUSY_LEVEL));
        head        = mem[rd_q];
    end

    // Store the pushed record.
    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_data;
    end

    // Keep the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (take) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (push && !take)      cnt_q <= cnt_q + 1'b1;
            else if (take && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R9
    drop_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop) |=> (cnt_q == CW'(DEPTH)));
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/rob_framer.sv
// Frame builder.
// Takes one queued record at a time and sends a header (crossing number), NDATA data words
// (most significant slice first) and a trailer carrying the sticky discard flag.
// Assumes REC_W = NDATA * WORD_W and WORD_W >= BCN_W.
module rob_framer
    import rob_pkg::*;
#(
    parameter int REC_W  = 32,
    parameter int WORD_W = 16,
    localparam int NDATA = REC_W / WORD_W,
    localparam int IW    = (NDATA > 1) ? $clog2(NDATA) : 1,
    localparam int ENT_W = BCN_W + REC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              readout_en,
    input  logic              fifo_valid,
    input  logic [ENT_W-1:0]  fifo_head,
    input  logic              drop,
    output logic              fifo_pop,
    output logic              out_valid,
    output logic [WORD_W+1:0] out_word
);
    word_type_t       state_q, state_n;
    logic [IW-1:0]    idx_q, idx_n;
    logic [ENT_W-1:0] cur_q;
    logic             err_q;
    logic             adv;
    logic [REC_W-1:0] cur_rec;
    logic [BCN_W-1:0] cur_bcn;
    logic [WORD_W-1:0] payload;

    assign cur_rec = cur_q[REC_W-1:0];
    assign cur_bcn = cur_q[ENT_W-1:REC_W];
    assign adv     = readout_en && (state_q != WT_IDLE);

    // Choose the next framer step and when to take a record.
    always_comb begin
        state_n  = state_q;
        idx_n    = idx_q;
        fifo_pop = 1'b0;
        unique case (state_q)
            WT_IDLE: if (fifo_valid) begin
                fifo_pop = 1'b1;
                state_n  = WT_HDR;
            end
            WT_HDR: if (adv) begin
                state_n = WT_DATA;
                idx_n   = '0;
            end
            WT_DATA: if (adv) begin
                if (idx_q == IW'(NDATA - 1)) state_n = WT_TRL;
                else                         idx_n   = idx_q + 1'b1;
            end
            WT_TRL: if (adv) begin
                if (fifo_valid) begin
                    fifo_pop = 1'b1;
                    state_n  = WT_HDR;
                end else begin
                    state_n = WT_IDLE;
                end
            end
        endcase
    end

    // Register the framer step and the record being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WT_IDLE;
            idx_q   <= '0;
            cur_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            if (fifo_pop) cur_q <= fifo_head;
        end
    end

    // Hold the discard flag until a trailer carries it out; a new discard wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                          err_q <= 1'b0;
        else if (drop)                       err_q <= 1'b1;
        else if (adv && state_q == WT_TRL)   err_q <= 1'b0;
    end

    // Form the payload of the current word.
    always_comb begin
        unique case (state_q)
            WT_HDR:  payload = {{(WORD_W - BCN_W){1'b0}}, cur_bcn};
            WT_DATA: payload = cur_rec[(NDATA - 1 - int'(idx_q)) * WORD_W +: WORD_W];
            WT_TRL:  payload = {{(WORD_W - 1){1'b0}}, err_q};
            default: payload = '0;
        endcase
        out_valid = adv;
        out_word  = {state_q, payload};
    end

    // R6
    hold_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!readout_en && state_q != WT_IDLE) |=> ($stable(state_q) && $stable(cur_q)));
    // R9
    err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> err_q);
endmodule

// File: rtl/l1a_readout_buffer.sv
// Level-1 readout latency buffer, top level.
// Stores {crossing number, record} every crossing. On an accept it queues the entry written
// lat_offset crossings earlier, and sends queued entries as frames gated by readout_en.
// Assumes lat_offset stays in 1..DEPTH-1.
module l1a_readout_buffer
    import rob_pkg::*;
#(
    parameter int TOW_W      = 16,
    parameter int HIT_W      = 8,
    parameter int ROI_W      = 8,
    parameter int WORD_W     = 16,
    parameter int DEPTH      = 128,
    parameter int FIFO_DEPTH = 8,
    parameter int BUSY_LEVEL = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TOW_W-1:0]         tower_in,
    input  logic [HIT_W-1:0]         hits_in,
    input  logic [ROI_W-1:0]         roi_in,
    input  logic                     orbit,
    input  logic                     l1_accept,
    input  logic [$clog2(DEPTH)-1:0] lat_offset,
    input  logic                     readout_en,
    output logic                     out_valid,
    output logic [WORD_W+1:0]        out_word,
    output logic                     busy
);
    localparam int REC_W = TOW_W + HIT_W + ROI_W;
    localparam int ENT_W = BCN_W + REC_W;

    logic [BCN_W-1:0] bcn;
    logic [ENT_W-1:0] ring_out, fifo_head;
    logic             fifo_valid, fifo_pop, drop;

    rob_xing_counter #(.W(BCN_W)) u_bcn (
        .clk(clk), .rst_n(rst_n), .orbit(orbit), .bcn(bcn)
    );

    rob_latency_ring #(.W(ENT_W), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .wr_data({bcn, tower_in, hits_in, roi_in}),
        .offset(lat_offset), .rd_data(ring_out)
    );

    rob_accept_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH), .BUSY_LEVEL(BUSY_LEVEL)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(l1_accept), .push_data(ring_out),
        .pop(fifo_pop), .head(fifo_head), .not_empty(fifo_valid),
        .almost_full(busy), .dropped(drop)
    );

    rob_framer #(.REC_W(REC_W), .WORD_W(WORD_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .readout_en(readout_en),
        .fifo_valid(fifo_valid), .fifo_head(fifo_head), .drop(drop),
        .fifo_pop(fifo_pop), .out_valid(out_valid), .out_word(out_word)
    );

    // R8
    busy_has_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> fifo_valid);
endmodule

// File: tb/l1a_readout_buffer_bench.sv
module l1a_readout_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tower_in = '0;
    logic [7:0]  hits_in = '0, roi_in = '0;
    logic        orbit = 1'b0, l1_accept = 1'b0, readout_en = 1'b0;
    logic [6:0]  lat_offset = 7'd1;
    logic        out_valid, busy;
    logic [17:0] out_word;

    always #2 clk = ~clk;

    l1a_readout_buffer u_l1a_readout_buffer (
        .clk(clk), .rst_n(rst_n), .tower_in(tower_in), .hits_in(hits_in),
        .roi_in(roi_in), .orbit(orbit), .l1_accept(l1_accept),
        .lat_offset(lat_offset), .readout_en(readout_en),
        .out_valid(out_valid), .out_word(out_word), .busy(busy)
    );

    int checks = 0, errors = 0;
    // stimulus controls
    bit acc = 0, en = 0, orb = 0, push_ok = 1, err_mark = 0;
    logic [6:0] off = 7'd1;
    int force_bcn = -1;
    string cur_tag = "R4";
    // bench model
    int n = 0, bcn_m = 0, mon_pos = 0;
    bit busy_s = 0;
    logic [31:0] rec_hist [256];
    int          bcn_hist [256];
    // expected frames
    int          q_bcn [64];
    logic [31:0] q_rec [64];
    bit          q_err [64];
    string       q_tag [64];
    int q_head = 0, q_tail = 0;

    function automatic logic [31:0] rec_of(int c);
        logic [15:0] t = 16'((c * 37 + 11) & 16'hFFFF);
        logic [7:0]  h = 8'(c & 8'hFF) ^ 8'hA5;
        logic [7:0]  r = 8'((c * 3) & 8'hFF);
        return {t, h, r};
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic monitor();
        int typ = int'(out_word[17:16]);
        int pay = int'(out_word[15:0]);
        if (q_head == q_tail) begin
            chk(0, "R7", "word with no pending record", int'(out_word), 0);
            return;
        end
        case (mon_pos)
            0: begin
                chk(typ == 1, "R5", "header type", typ, 1);
                chk(pay == q_bcn[q_head % 64], q_tag[q_head % 64], "header crossing", pay, q_bcn[q_head % 64]);
            end
            1: begin
                chk(typ == 2, "R5", "data0 type", typ, 2);
                chk(pay == int'(q_rec[q_head % 64][31:16]), q_tag[q_head % 64], "tower word", pay,
                    int'(q_rec[q_head % 64][31:16]));
            end
            2: begin
                chk(typ == 2, "R5", "data1 type", typ, 2);
                chk(pay == int'(q_rec[q_head % 64][15:0]), q_tag[q_head % 64], "hits/roi word", pay,
                    int'(q_rec[q_head % 64][15:0]));
            end
            default: begin
                chk(typ == 3, "R5", "trailer type", typ, 3);
                chk(pay == int'(q_err[q_head % 64]), "R9", "trailer flag", pay, int'(q_err[q_head % 64]));
                q_head++;
            end
        endcase
        mon_pos = (mon_pos + 1) % 4;
    endtask

    // One crossing: drive at the falling edge, sample 1 ns later, then update the model.
    task automatic step();
        logic [31:0] rec = rec_of(n);
        @(negedge clk);
        rst_n = 1'b1;
        {tower_in, hits_in, roi_in} = rec;
        l1_accept = acc; readout_en = en; orbit = orb; lat_offset = off;
        #1;
        busy_s = busy;
        if (!en) chk(out_valid == 1'b0, "R6", "valid while disabled", int'(out_valid), 0);
        if (out_valid) monitor();
        rec_hist[n & 255] = rec;
        bcn_hist[n & 255] = bcn_m;
        if (acc && push_ok) begin
            int idx = (n - int'(off)) & 255;
            q_bcn[q_tail % 64] = (force_bcn >= 0) ? force_bcn : bcn_hist[idx];
            q_rec[q_tail % 64] = rec_hist[idx];
            q_err[q_tail % 64] = err_mark;
            q_tag[q_tail % 64] = cur_tag;
            q_tail++;
        end
        bcn_m = orb ? 0 : (bcn_m + 1) % 4096;
        n++;
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        step();
        chk(out_valid == 1'b0 && busy == 1'b0, "R1", "first cycle outputs", int'({out_valid, busy}), 0);

        en = 1;
        repeat (200) step();

        // R4: offset sweep
        foreach (q_err[i]) q_err[i] = 0;
        for (int k = 0; k < 8; k++) begin
            int offs [8] = '{1, 2, 3, 5, 17, 64, 100, 127};
            cur_tag = "R4"; off = 7'(offs[k]); acc = 1; step(); acc = 0;
            repeat (8) step();
        end

        // R7: consecutive accepts keep order
        cur_tag = "R7"; off = 7'd20;
        acc = 1; repeat (3) step(); acc = 0;
        repeat (20) step();

        // R3: orbit clears the crossing number
        orb = 1; step(); orb = 0; step();
        cur_tag = "R3"; force_bcn = 0; off = 7'd1; acc = 1; step();
        acc = 0; force_bcn = -1;
        repeat (10) step();

        // R6: random enable gaps with random accepts
        cur_tag = "R6"; off = 7'd40;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            en  = (lfsr[1:0] != 2'b00);
            acc = !busy_s && (lfsr[5:3] == 3'b000);
            step();
        end
        acc = 0; en = 1;
        repeat (40) step();

        // R2: wrap from 4095 to 0
        while (bcn_m != 4095) step();
        step();
        cur_tag = "R2"; off = 7'd1; acc = 1; force_bcn = 4095; step();
        force_bcn = 0; step();
        acc = 0; force_bcn = -1;
        repeat (20) step();

        // R8/R9: burst into a disabled output
        en = 0; off = 7'd10; cur_tag = "R7";
        for (int j = 0; j <= 10; j++) begin
            acc = 1; push_ok = (j <= 8); err_mark = (j == 0);
            step();
            if (j == 6) chk(busy_s == 1'b0, "R8", "busy at five queued", int'(busy_s), 0);
            if (j == 7) chk(busy_s == 1'b1, "R8", "busy at six queued", int'(busy_s), 1);
        end
        acc = 0; push_ok = 1; err_mark = 0;
        repeat (3) begin
            step();
            chk(busy_s == 1'b1, "R8", "busy while full", int'(busy_s), 1);
        end
        en = 1;
        for (int i = 0; i < 36; i++) begin
            step();
            chk(out_valid == 1'b1, "R10", "gap between frames", int'(out_valid), 1);
        end
        repeat (10) step();
        chk(busy_s == 1'b0, "R8", "busy after drain", int'(busy_s), 0);
        chk(q_head == q_tail, "R7", "frames still pending", q_tail - q_head, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule